// File: doc/BRIEF.md
# Data Segment Resolver and Physical Address Former

This block decides, for each data access of a real-mode processor core, which of the six segment registers forms the base of the access, and adds the shifted segment to the offset to give a physical address. Decode logic pulses a per-segment strobe when it sees a segment-override prefix. It pulses a stack-relative flag when a base-pointer addressing form means the access defaults to the stack segment. It pulses an end-of-instruction signal when a non-prefix instruction retires. These events build a small per-instruction mode state. Each access is resolved against that state.

With no override held, the access goes to the data segment, or to the stack segment when the stack-relative bit is held. A single held override wins over the default choice. Two or more held overrides are an illegal combination: the access is flagged and the block raises a sticky halt request. Absolute accesses carry their own segment value and skip the mode state. The physical address keeps the carry past the 1 MB boundary.

The mode state is a four-state machine:
- `ST_CLEAN`: no override held.
- `ST_SINGLE`: exactly one override held.
- `ST_MULTI`: two or more overrides held.
- `ST_HALT`: terminal after a faulting access.

Its transitions are:
- ADD (a strobe adds bits; the next state follows the new count).
- CLEAR (end of instruction returns to `ST_CLEAN`, keeping only strobes of the same cycle).
- FAULT (a non-absolute access in `ST_MULTI` goes to `ST_HALT`).
- HOLD (`ST_HALT` ignores all events until reset).

Top module: `seg_resolver`

## Requirements
- R1: After reset the state is clean, `halt_req` is 0, and a non-absolute access selects `seg_ds`.
- R2: With no override held and the stack-relative bit clear, `sel_seg` equals `seg_ds`.
- R3: With no override held and the stack-relative bit set, `sel_seg` equals `seg_ss`.
- R4: Strobe bit positions are 0=ES, 1=CS, 2=SS, 3=DS, 4=FS, 5=GS. When exactly one override is held, its segment is selected whatever the stack-relative bit is.
- R5: With two or more overrides held, a non-absolute access drives `addr_err`=1 and `sel_seg`=0 in the same cycle.
- R6: An access with `addr_err`=1 makes `halt_req` 1 from the next cycle. `halt_req` then stays 1, and strobes and `instr_end` have no effect, until reset.
- R7: `instr_end` clears all override bits and the stack-relative bit, effective from the next cycle.
- R8: Strobes and the stack-relative flag given in separate cycles accumulate until `instr_end`.
- R9: A strobe in the same cycle as `instr_end` survives the clear. A stack-relative pulse in that cycle does not survive.
- R10: `phys_addr` = (`sel_seg` << 4) + `acc_off`, 21 bits wide, so FFFF:FFFF gives 0x10FFEF.
- R11: With `acc_abs`=1, `sel_seg` equals `abs_seg` and `addr_err` is 0, even when several overrides are held.
- R12: Mode events take effect from the clock edge that samples them. An access in the same cycle sees the earlier state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pfx_strobe | input | 6 | Override strobes, one bit per segment |
| stk_rel_set | input | 1 | Stack-relative default requested by address decode |
| instr_end | input | 1 | Non-prefix instruction retired; clears mode state |
| seg_es | input | 16 | ES register value |
| seg_cs | input | 16 | CS register value |
| seg_ss | input | 16 | SS register value |
| seg_ds | input | 16 | DS register value |
| seg_fs | input | 16 | FS register value |
| seg_gs | input | 16 | GS register value |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_abs | input | 1 | Access uses `abs_seg` and skips resolution |
| abs_seg | input | 16 | Explicit segment for absolute accesses |
| acc_off | input | 16 | Access offset |
| sel_seg | output | 16 | Resolved segment value |
| phys_addr | output | 21 | Physical address |
| addr_err | output | 1 | Access hit conflicting overrides |
| halt_req | output | 1 | Sticky halt request |

## Verification
The hardest situation to reach is the conflict path. Decode would never normally hold two overrides, so the bench builds the conflict on purpose: it gives two strobes in separate cycles with no `instr_end` between them, then presents a non-absolute access. After that access it keeps pulsing `instr_end` and strobes, to show that the halted state ignores them. The same cycle-by-cycle accumulation covers the order-sensitive case of a strobe that coincides with `instr_end`.

// File: rtl/segres_pkg.sv
package segres_pkg;

    localparam int NSEG   = 6;
    localparam int SEG_ES = 0;
    localparam int SEG_CS = 1;
    localparam int SEG_SS = 2;
    localparam int SEG_DS = 3;
    localparam int SEG_FS = 4;
    localparam int SEG_GS = 5;

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'd0,
        ST_SINGLE = 2'd1,
        ST_MULTI  = 2'd2,
        ST_HALT   = 2'd3
    } mode_st_t;

    function automatic int unsigned bit_count(input logic [NSEG-1:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < NSEG; i++) begin
            n = n + int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/seg_mode_fsm.sv
module seg_mode_fsm
    import segres_pkg::*;
#(
    parameter int N = NSEG
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe_i,
    input  logic         stk_set_i,
    input  logic         end_i,
    input  logic         fault_i,
    output logic [N-1:0] ovr_o,
    output logic         stk_o,
    output logic         multi_o,
    output logic         halt_o
);

    mode_st_t     st_q, st_d;
    logic [N-1:0] ovr_q, ovr_d;
    logic         stk_q, stk_d;
    logic [N-1:0] base_ovr;

    // Next-state process
    always_comb begin
        st_d     = st_q;
        ovr_d    = ovr_q;
        stk_d    = stk_q;
        base_ovr = end_i ? '0 : ovr_q;
        unique case (st_q)
            ST_CLEAN, ST_SINGLE, ST_MULTI: begin
                if (fault_i) begin
                    st_d = ST_HALT;                      // FAULT
                end else begin
                    ovr_d = base_ovr | strobe_i;         // ADD / CLEAR
                    stk_d = end_i ? 1'b0 : (stk_q | stk_set_i);
                    if (bit_count(ovr_d) == 0) begin
                        st_d = ST_CLEAN;
                    end else if (bit_count(ovr_d) == 1) begin
                        st_d = ST_SINGLE;
                    end else begin
                        st_d = ST_MULTI;
                    end
                end
            end
            ST_HALT: begin
                st_d = ST_HALT;                          // HOLD
            end
            default: st_d = ST_HALT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_CLEAN;
            ovr_q <= '0;
            stk_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            ovr_q <= ovr_d;
            stk_q <= stk_d;
        end
    end

    // Output process
    always_comb begin
        ovr_o   = ovr_q;
        stk_o   = stk_q;
        multi_o = 1'b0;
        halt_o  = 1'b0;
        unique case (st_q)
            ST_CLEAN:  ;
            ST_SINGLE: ;
            ST_MULTI:  multi_o = 1'b1;
            ST_HALT: begin
                multi_o = 1'b1;
                halt_o  = 1'b1;
            end
            default: halt_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/seg_select_mux.sv
module seg_select_mux
    import segres_pkg::*;
#(
    parameter int N     = NSEG,
    parameter int SEG_W = 16
) (
    input  logic [N-1:0][SEG_W-1:0] bank_i,
    input  logic [N-1:0]            ovr_i,
    input  logic                    stk_i,
    input  logic                    multi_i,
    input  logic                    abs_i,
    input  logic [SEG_W-1:0]        abs_seg_i,
    output logic [SEG_W-1:0]        sel_o
);

    logic [N-1:0][SEG_W-1:0] gated;
    logic [SEG_W-1:0]        ovr_val;
    logic                    any_ovr;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_gate
            assign gated[g] = ovr_i[g] ? bank_i[g] : '0;
        end
    endgenerate

    always_comb begin
        ovr_val = '0;
        for (int i = 0; i < N; i++) begin
            ovr_val = ovr_val | gated[i];
        end
        any_ovr = |ovr_i;
    end

    always_comb begin
        if (abs_i) begin
            sel_o = abs_seg_i;
        end else if (multi_i) begin
            sel_o = '0;
        end else if (any_ovr) begin
            sel_o = ovr_val;
        end else if (stk_i) begin
            sel_o = bank_i[SEG_SS];
        end else begin
            sel_o = bank_i[SEG_DS];
        end
    end

endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int SUM_W = ((SEG_W + SHIFT) > OFF_W) ? (SEG_W + SHIFT) : OFF_W,
    localparam int PA_W  = SUM_W + 1
) (
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PA_W-1:0]  pa_o
);

    logic [PA_W-1:0] base_ext;
    logic [PA_W-1:0] off_ext;

    always_comb begin
        base_ext = PA_W'({seg_i, {SHIFT{1'b0}}});
        off_ext  = PA_W'(off_i);
        pa_o     = base_ext + off_ext;
    end

endmodule

// File: rtl/seg_resolver.sv
module seg_resolver
    import segres_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int SUM_W = ((SEG_W + SHIFT) > OFF_W) ? (SEG_W + SHIFT) : OFF_W,
    localparam int PA_W  = SUM_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSEG-1:0]  pfx_strobe,
    input  logic             stk_rel_set,
    input  logic             instr_end,
    input  logic [SEG_W-1:0] seg_es,
    input  logic [SEG_W-1:0] seg_cs,
    input  logic [SEG_W-1:0] seg_ss,
    input  logic [SEG_W-1:0] seg_ds,
    input  logic [SEG_W-1:0] seg_fs,
    input  logic [SEG_W-1:0] seg_gs,
    input  logic             acc_valid,
    input  logic             acc_abs,
    input  logic [SEG_W-1:0] abs_seg,
    input  logic [OFF_W-1:0] acc_off,
    output logic [SEG_W-1:0] sel_seg,
    output logic [PA_W-1:0]  phys_addr,
    output logic             addr_err,
    output logic             halt_req
);

    logic [NSEG-1:0][SEG_W-1:0] bank;
    logic [NSEG-1:0]            ovr;
    logic                       stk;
    logic                       multi;
    logic                       fault;

    always_comb begin
        bank[SEG_ES] = seg_es;
        bank[SEG_CS] = seg_cs;
        bank[SEG_SS] = seg_ss;
        bank[SEG_DS] = seg_ds;
        bank[SEG_FS] = seg_fs;
        bank[SEG_GS] = seg_gs;
    end

    assign fault    = acc_valid & ~acc_abs & multi;
    assign addr_err = fault;

    seg_mode_fsm #(.N(NSEG)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_i  (pfx_strobe),
        .stk_set_i (stk_rel_set),
        .end_i     (instr_end),
        .fault_i   (fault),
        .ovr_o     (ovr),
        .stk_o     (stk),
        .multi_o   (multi),
        .halt_o    (halt_req)
    );

    seg_select_mux #(.N(NSEG), .SEG_W(SEG_W)) u_mux (
        .bank_i    (bank),
        .ovr_i     (ovr),
        .stk_i     (stk),
        .multi_i   (multi),
        .abs_i     (acc_abs),
        .abs_seg_i (abs_seg),
        .sel_o     (sel_seg)
    );

    seg_addr_calc #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_addr (
        .seg_i (sel_seg),
        .off_i (acc_off),
        .pa_o  (phys_addr)
    );

endmodule

// File: rtl/segres_chk.sv
module segres_chk #(
    parameter int SEG_W = 16,
    parameter int PA_W  = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic [5:0]       pfx_strobe,
    input logic             instr_end,
    input logic [SEG_W-1:0] seg_ds,
    input logic             acc_valid,
    input logic             acc_abs,
    input logic [SEG_W-1:0] abs_seg,
    input logic [SEG_W-1:0] sel_seg,
    input logic             addr_err,
    input logic             halt_req
);

    // R5: a conflicting access never reports a segment
    a_r5_err_zero_seg: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (sel_seg == '0));

    // R6: a faulting access requests a halt in the next cycle
    a_r6_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> halt_req);

    // R6: the halt request holds until reset
    a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> halt_req);

    // R7: a clear with no new strobe returns to the data segment default
    a_r7_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_end && (pfx_strobe == '0) && !halt_req && !addr_err)
        |=> (acc_abs || (sel_seg == seg_ds)));

    // R11: absolute accesses take the supplied segment and never fault
    a_r11_abs_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_abs) |-> ((sel_seg == abs_seg) && !addr_err));

endmodule

bind seg_resolver segres_chk #(.SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pfx_strobe (pfx_strobe),
    .instr_end  (instr_end),
    .seg_ds     (seg_ds),
    .acc_valid  (acc_valid),
    .acc_abs    (acc_abs),
    .abs_seg    (abs_seg),
    .sel_seg    (sel_seg),
    .addr_err   (addr_err),
    .halt_req   (halt_req)
);

// File: tb/tb_seg_resolver.sv
module tb_seg_resolver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  pfx_strobe = '0;
    logic        stk_rel_set = 1'b0;
    logic        instr_end = 1'b0;
    logic [15:0] seg_es = 16'h1000, seg_cs = 16'h2000, seg_ss = 16'h3000;
    logic [15:0] seg_ds = 16'h4000, seg_fs = 16'h5000, seg_gs = 16'h6000;
    logic        acc_valid = 1'b0;
    logic        acc_abs = 1'b0;
    logic [15:0] abs_seg = '0;
    logic [15:0] acc_off = '0;
    logic [15:0] sel_seg;
    logic [20:0] phys_addr;
    logic        addr_err;
    logic        halt_req;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;   // 250 MHz

    seg_resolver dut (.*);

    typedef struct packed {
        logic [5:0]  pfx;
        logic        stk;
        logic        abs_f;
        logic [15:0] aseg;
        logic [15:0] off;
        logic [15:0] eseg;
    } vec_t;

    // strobe bits: 0=ES 1=CS 2=SS 3=DS 4=FS 5=GS
    localparam vec_t TBL [10] = '{
        '{6'h00, 1'b0, 1'b0, 16'h0000, 16'h0010, 16'h4000},  // R2
        '{6'h00, 1'b1, 1'b0, 16'h0000, 16'h0020, 16'h3000},  // R3
        '{6'h01, 1'b1, 1'b0, 16'h0000, 16'h0030, 16'h1000},  // R4 ES
        '{6'h02, 1'b0, 1'b0, 16'h0000, 16'h0040, 16'h2000},  // R4 CS
        '{6'h20, 1'b1, 1'b0, 16'h0000, 16'h0050, 16'h6000},  // R4 GS
        '{6'h10, 1'b0, 1'b0, 16'h0000, 16'h0060, 16'h5000},  // R4 FS
        '{6'h08, 1'b1, 1'b0, 16'h0000, 16'h0070, 16'h4000},  // R4 DS over stack
        '{6'h04, 1'b0, 1'b0, 16'h0000, 16'h0080, 16'h3000},  // R4 SS
        '{6'h03, 1'b0, 1'b1, 16'hABCD, 16'h0001, 16'hABCD},  // R11 abs with conflict
        '{6'h00, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF}   // R10 carry
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [20:0] pa_of(input logic [15:0] s, input logic [15:0] o);
        return {1'b0, s, 4'h0} + {5'h0, o};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        pfx_strobe = '0; stk_rel_set = 1'b0; instr_end = 1'b0;
        acc_valid = 1'b0; acc_abs = 1'b0; abs_seg = '0; acc_off = '0;
    endtask

    task automatic access(input logic a, input logic [15:0] s, input logic [15:0] o);
        idle_inputs();
        acc_valid = 1'b1; acc_abs = a; abs_seg = s; acc_off = o;
        #1;
    endtask

    task automatic end_instr();
        tick(); idle_inputs(); instr_end = 1'b1;
        tick(); idle_inputs();
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        access(1'b0, '0, 16'h0004);
        check("R1 halt", 32'(halt_req), 32'h0);
        check("R1 seg", 32'(sel_seg), 32'h4000);
        check("R1 err", 32'(addr_err), 32'h0);

        // table walk
        for (int i = 0; i < 10; i++) begin
            tick(); idle_inputs();
            pfx_strobe = TBL[i].pfx; stk_rel_set = TBL[i].stk;
            tick();
            access(TBL[i].abs_f, TBL[i].aseg, TBL[i].off);
            check($sformatf("R4/R11 vec%0d seg", i), 32'(sel_seg), 32'(TBL[i].eseg));
            check($sformatf("R10 vec%0d pa", i), 32'(phys_addr), 32'(pa_of(TBL[i].eseg, TBL[i].off)));
            check($sformatf("R5 vec%0d err", i), 32'(addr_err), 32'h0);
            end_instr();
        end
        check("R10 top pa", 32'(pa_of(16'hFFFF, 16'hFFFF)), 32'h10FFEF);

        // R12: strobe and access in the same cycle see the old state
        tick(); idle_inputs();
        pfx_strobe = 6'h02; acc_valid = 1'b1; acc_off = 16'h0001; #1;
        check("R12 same cycle", 32'(sel_seg), 32'h4000);
        tick();
        access(1'b0, '0, 16'h0001);
        check("R12 next cycle", 32'(sel_seg), 32'h2000);
        // R7: clear returns to data segment
        end_instr();
        access(1'b0, '0, 16'h0002);
        check("R7 cleared", 32'(sel_seg), 32'h4000);

        // R8: separate cycles accumulate
        tick(); idle_inputs(); pfx_strobe = 6'h01;
        tick(); idle_inputs(); stk_rel_set = 1'b1;
        tick(); idle_inputs();
        tick();
        access(1'b0, '0, 16'h0003);
        check("R8 accum", 32'(sel_seg), 32'h1000);
        end_instr();
        tick(); idle_inputs(); stk_rel_set = 1'b1;
        tick(); idle_inputs();
        tick();
        access(1'b0, '0, 16'h0003);
        check("R8 stk kept", 32'(sel_seg), 32'h3000);
        end_instr();

        // R9: strobe coincident with clear survives; stack pulse does not
        tick(); idle_inputs(); pfx_strobe = 6'h01;
        tick(); idle_inputs(); pfx_strobe = 6'h20; instr_end = 1'b1;
        tick();
        access(1'b0, '0, 16'h0005);
        check("R9 strobe kept", 32'(sel_seg), 32'h6000);
        check("R9 no conflict", 32'(addr_err), 32'h0);
        end_instr();
        tick(); idle_inputs(); stk_rel_set = 1'b1; instr_end = 1'b1;
        tick();
        access(1'b0, '0, 16'h0005);
        check("R9 stk dropped", 32'(sel_seg), 32'h4000);
        end_instr();

        // R5/R6: conflict built over two cycles
        tick(); idle_inputs(); pfx_strobe = 6'h01;
        tick(); idle_inputs(); pfx_strobe = 6'h04;
        tick();
        access(1'b0, '0, 16'h0006);
        check("R5 err", 32'(addr_err), 32'h1);
        check("R5 seg zero", 32'(sel_seg), 32'h0);
        check("R6 not yet", 32'(halt_req), 32'h0);
        tick(); idle_inputs(); #1;
        check("R6 halt", 32'(halt_req), 32'h1);
        instr_end = 1'b1; pfx_strobe = 6'h08;
        tick(); idle_inputs();
        tick();
        access(1'b0, '0, 16'h0006);
        check("R6 sticky", 32'(halt_req), 32'h1);
        check("R6 end ignored", 32'(addr_err), 32'h1);

        // R1: reset leaves halt
        do_reset();
        access(1'b0, '0, 16'h0000);
        check("R1 halt cleared", 32'(halt_req), 32'h0);
        check("R1 default", 32'(sel_seg), 32'h4000);
        tick(); idle_inputs();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule